// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation Unit

This block lets a transmitting CAN FD node check its own data-phase bits even when the transceiver loop delay is longer than a bit. It keeps a configuration word that holds an enable flag, a six-bit offset in CAN clock cycles and an eight-bit data-phase prescaler. Software can change that word only while the controller is disabled.

After a measure strobe, the block counts CAN clock cycles from the next falling edge on the transmit line to the next falling edge on the receive line. That count is the loop delay. The secondary sample point (SSP) is the loop delay plus the offset, and the sum is clipped at 127.

Every data bit launched while compensation is enabled goes into a small queue together with its own countdown. This lets a bit be checked after later bits have started. When a countdown expires, the block compares the receive line with the stored bit and raises a one-cycle error pulse if they differ.

Top module: `can_tdc_unit`

## Requirements
- R1: After reset, `cfg_rdata`, `loop_delay`, `ssp_pos` and `bit_err` are all zero, and `prescale_eff` is 1.
- R2: A write with `ctrl_en` low stores the word with this layout: bit 16 is the enable, bits 13:8 are the offset and bits 7:0 are the prescaler. Bits 15:14 always read back as zero.
- R3: A write with `ctrl_en` high leaves `cfg_rdata` unchanged.
- R4: `prescale_eff` equals the stored prescaler field plus one, for example 0 gives 1 and 255 gives 256.
- R5: After `meas_start`, `loop_delay` equals the number of clock edges from the edge that first samples the transmit line low to the edge that first samples the receive line low. A receive falling edge that comes before the transmit falling edge is ignored.
- R6: If no receive falling edge arrives within 127 cycles of the transmit falling edge, `loop_delay` becomes 127.
- R7: `ssp_pos` equals `loop_delay` plus the offset, clipped to 127.
- R8: For a bit launched at clock edge L, the receive line is sampled at edge L+`ssp_pos`. If it differs from `tx_bit`, `bit_err` is high for exactly the one cycle after that edge.
- R9: While the enable bit is 0, launched bits are not checked and `bit_err` stays low.
- R10: Up to four launched bits can be outstanding at once, and each is checked against its own value at its own sample time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctrl_en | input | 1 | Controller enabled; blocks configuration writes while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 17 | Configuration write data |
| cfg_rdata | output | 17 | Stored configuration word |
| prescale_eff | output | 9 | Effective data-phase prescaler (field plus one) |
| meas_start | input | 1 | Arms a loop-delay measurement |
| tx_line | input | 1 | Transmit line as driven to the transceiver |
| rx_line | input | 1 | Receive line from the transceiver |
| bit_launch | input | 1 | A data bit starts this cycle |
| tx_bit | input | 1 | Value of the bit being launched |
| loop_delay | output | 7 | Last measured loop delay in cycles |
| ssp_pos | output | 7 | Secondary sample point, delay plus offset, clipped to 127 |
| bit_err | output | 1 | One-cycle mismatch pulse |

## Verification
The hardest case to reach is several launched bits in flight at the same time, with one mismatch falling on a later bit. To get there, the stimulus first sets a short loop delay through a real measurement. It then launches four bits three cycles apart, which keeps up to three bits outstanding at once. The receive line is held constant during this sequence. As a result, only the launched zeros should produce errors, each exactly at its launch edge plus the SSP.

The saturation cases are reached in two ways. One uses a long measured delay plus a large offset. The other never delivers the receive edge, so the 127-cycle limit is forced.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int CFG_W   = 17;
  localparam int OFF_W   = 6;
  localparam int PRE_W   = 8;
  localparam int DLY_W   = 7;
  localparam int DLY_MAX = (1 << DLY_W) - 1;

  typedef struct packed {
    logic             en;
    logic [1:0]       rsvd;
    logic [OFF_W-1:0] offset;
    logic [PRE_W-1:0] presc;
  } tdc_cfg_t;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_ARMED = 2'd1,
    M_COUNT = 2'd2
  } meas_st_e;
endpackage

// File: rtl/tdc_cfg_reg.sv
module tdc_cfg_reg
  import tdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output tdc_cfg_t         cfg
);
  tdc_cfg_t cfg_d, cfg_q;

  // Writes are accepted only while the controller is disabled.
  always_comb begin
    cfg_d = cfg_q;
    if (we && !ctrl_en) begin
      cfg_d      = tdc_cfg_t'(wdata);
      cfg_d.rsvd = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas
  import tdc_pkg::*;
#(
  parameter int DW   = DLY_W,
  parameter int OW   = OFF_W,
  localparam int MAXV = (1 << DW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tx,
  input  logic          rx,
  input  logic [OW-1:0] offset,
  output logic [DW-1:0] delay,
  output logic [DW-1:0] ssp
);
  meas_st_e      st_d, st_q;
  logic [DW-1:0] cnt_d, cnt_q, dly_d, dly_q;
  logic          tx_prev_q, rx_prev_q;
  logic          tx_fall, rx_fall;
  logic [DW:0]   sum;

  assign tx_fall = tx_prev_q & ~tx;
  assign rx_fall = rx_prev_q & ~rx;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    dly_d = dly_q;
    unique case (st_q)
      M_IDLE: ;
      M_ARMED: begin
        if (tx_fall) begin
          st_d  = M_COUNT;
          cnt_d = DW'(1);
        end
      end
      M_COUNT: begin
        if (rx_fall) begin
          dly_d = cnt_q;
          st_d  = M_IDLE;
        end else if (cnt_q == DW'(MAXV)) begin
          dly_d = DW'(MAXV);
          st_d  = M_IDLE;
        end else begin
          cnt_d = cnt_q + DW'(1);
        end
      end
      default: st_d = M_IDLE;
    endcase
    if (start) st_d = M_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= M_IDLE;
      cnt_q     <= '0;
      dly_q     <= '0;
      tx_prev_q <= 1'b1;
      rx_prev_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      dly_q     <= dly_d;
      tx_prev_q <= tx;
      rx_prev_q <= rx;
    end
  end

  assign sum   = {1'b0, dly_q} + (DW+1)'(offset);
  assign ssp   = (sum > (DW+1)'(MAXV)) ? DW'(MAXV) : sum[DW-1:0];
  assign delay = dly_q;
endmodule

// File: rtl/tdc_ssp_check.sv
module tdc_ssp_check
  import tdc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = DLY_W,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          launch,
  input  logic          tx_bit,
  input  logic          rx,
  input  logic [DW-1:0] ssp,
  output logic          bit_err
);
  logic [PW-1:0]    wp_d, wp_q;
  logic [DEPTH-1:0] hit;
  logic             err_q;

  always_comb begin
    wp_d = wp_q;
    if (!chk_en)     wp_d = '0;
    else if (launch) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          vld_d, vld_q, bit_d, bit_q, load, hit_s;
    logic [DW-1:0] cnt_d, cnt_q;

    assign load = chk_en && launch && (wp_q == PW'(g));

    always_comb begin
      vld_d = vld_q;
      bit_d = bit_q;
      cnt_d = cnt_q;
      hit_s = 1'b0;
      if (!chk_en) begin
        vld_d = 1'b0;
      end else begin
        if (vld_q) begin
          if (cnt_q == '0) begin
            vld_d = 1'b0;
            hit_s = (rx != bit_q);
          end else begin
            cnt_d = cnt_q - DW'(1);
          end
        end
        if (load) begin
          vld_d = 1'b1;
          bit_d = tx_bit;
          cnt_d = (ssp == '0) ? '0 : ssp - DW'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        bit_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        vld_q <= vld_d;
        bit_q <= bit_d;
        cnt_q <= cnt_d;
      end
    end

    assign hit[g] = hit_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      err_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      err_q <= |hit;
    end
  end

  assign bit_err = err_q;
endmodule

// File: rtl/can_tdc_unit.sv
module can_tdc_unit
  import tdc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [PRE_W:0]   prescale_eff,
  input  logic             meas_start,
  input  logic             tx_line,
  input  logic             rx_line,
  input  logic             bit_launch,
  input  logic             tx_bit,
  output logic [DLY_W-1:0] loop_delay,
  output logic [DLY_W-1:0] ssp_pos,
  output logic             bit_err
);
  logic [1:0] rs_q;
  logic       rst_i_n;
  tdc_cfg_t   cfg;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  tdc_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .ctrl_en(ctrl_en),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .cfg    (cfg)
  );

  tdc_delay_meas #(.DW(DLY_W), .OW(OFF_W)) u_meas (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (meas_start),
    .tx    (tx_line),
    .rx    (rx_line),
    .offset(cfg.offset),
    .delay (loop_delay),
    .ssp   (ssp_pos)
  );

  tdc_ssp_check #(.DEPTH(DEPTH), .DW(DLY_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .chk_en (cfg.en),
    .launch (bit_launch),
    .tx_bit (tx_bit),
    .rx     (rx_line),
    .ssp    (ssp_pos),
    .bit_err(bit_err)
  );

  assign cfg_rdata    = cfg;
  assign prescale_eff = {1'b0, cfg.presc} + (PRE_W+1)'(1);
endmodule

// File: rtl/can_tdc_unit_chk.sv
module can_tdc_unit_chk
  import tdc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic [PRE_W:0]   prescale_eff,
  input logic [DLY_W-1:0] loop_delay,
  input logic [DLY_W-1:0] ssp_pos,
  input logic             bit_err
);
  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> $stable(cfg_rdata));

  // R9
  err_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(cfg_rdata[16]));

  // R7
  ssp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssp_pos >= loop_delay);

  // R5
  delay_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(loop_delay) |-> loop_delay != '0);

  // R4
  presc_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prescale_eff == ({1'b0, cfg_rdata[PRE_W-1:0]} + (PRE_W+1)'(1)));
endmodule

bind can_tdc_unit can_tdc_unit_chk u_tdc_chk (.*);

// File: tb/tb_can_tdc_unit.sv
module tb_can_tdc_unit;
  logic        clk;
  logic        rst_n;
  logic        ctrl_en;
  logic        cfg_we;
  logic [16:0] cfg_wdata;
  logic [16:0] cfg_rdata;
  logic [8:0]  prescale_eff;
  logic        meas_start;
  logic        tx_line;
  logic        rx_line;
  logic        bit_launch;
  logic        tx_bit;
  logic [6:0]  loop_delay;
  logic [6:0]  ssp_pos;
  logic        bit_err;

  int checks = 0;
  int errors = 0;

  can_tdc_unit dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prescale_eff(prescale_eff),
    .meas_start(meas_start), .tx_line(tx_line), .rx_line(rx_line),
    .bit_launch(bit_launch), .tx_bit(tx_bit), .loop_delay(loop_delay),
    .ssp_pos(ssp_pos), .bit_err(bit_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(logic lock, logic [16:0] data);
    ctrl_en   = lock;
    cfg_we    = 1'b1;
    cfg_wdata = data;
    step();
    cfg_we    = 1'b0;
    ctrl_en   = 1'b0;
    step();
  endtask

  task automatic measure(int d, logic no_rx);
    meas_start = 1'b1; step(); meas_start = 1'b0;
    rx_line = 1'b0; step(); rx_line = 1'b1; step();   // early rx edge, ignored
    tx_line = 1'b0; step();
    if (no_rx) repeat (140) step();
    else begin
      repeat (d - 1) step();
      rx_line = 1'b0; step();
    end
    tx_line = 1'b1; rx_line = 1'b1; step(); step();
  endtask

  task automatic t_reset();
    check("R1 cfg_rdata", cfg_rdata, 0);
    check("R1 loop_delay", loop_delay, 0);
    check("R1 ssp_pos", ssp_pos, 0);
    check("R1 bit_err", bit_err, 0);
    check("R1 prescale_eff", prescale_eff, 1);
  endtask

  task automatic t_cfg();
    cfg_write(1'b0, 17'h1FFFF);
    check("R2 layout/rsvd zero", cfg_rdata, 17'h13FFF);
    check("R4 presc 255", prescale_eff, 256);
    cfg_write(1'b1, 17'h00000);
    check("R3 locked write", cfg_rdata, 17'h13FFF);
    cfg_write(1'b0, 17'h10304);
    check("R2 en/off3/presc4", cfg_rdata, 17'h10304);
    check("R4 presc 4", prescale_eff, 5);
  endtask

  task automatic t_measure5();
    measure(5, 1'b0);
    check("R5 delay", loop_delay, 5);
    check("R7 ssp 5+3", ssp_pos, 8);
  endtask

  task automatic t_single(logic txv, logic rxv, int exp);
    rx_line = 1'b1; bit_launch = 1'b1; tx_bit = txv; step();
    bit_launch = 1'b0;
    repeat (7) step();
    check("R8 quiet before SSP", bit_err, 0);
    rx_line = rxv; step();
    check("R8 at SSP", bit_err, exp);
    rx_line = 1'b1; step();
    check("R8 one cycle", bit_err, 0);
  endtask

  task automatic t_queue();
    int bad = 0;
    rx_line = 1'b1;
    for (int c = 0; c < 20; c++) begin
      bit_launch = (c == 0) || (c == 3) || (c == 6) || (c == 9);
      tx_bit     = (c == 0) || (c == 6);
      step();
      bit_launch = 1'b0;
      if (bit_err != ((c == 11) || (c == 17))) begin
        bad++;
        $display("FAIL R10 cycle %0d actual=%0d expected=%0d", c, bit_err,
                 (c == 11) || (c == 17));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic t_disabled();
    int seen = 0;
    cfg_write(1'b0, 17'h00304);
    rx_line = 1'b0; bit_launch = 1'b1; tx_bit = 1'b1; step();
    bit_launch = 1'b0;
    for (int i = 0; i < 14; i++) begin
      step();
      if (bit_err) seen++;
    end
    rx_line = 1'b1;
    check("R9 no error when off", seen, 0);
  endtask

  task automatic t_saturate();
    cfg_write(1'b0, 17'h13C04);
    measure(100, 1'b0);
    check("R5 delay 100", loop_delay, 100);
    check("R7 ssp clipped", ssp_pos, 127);
    cfg_write(1'b0, 17'h10000);
    measure(0, 1'b1);
    check("R6 no rx edge", loop_delay, 127);
    check("R7 ssp off 0", ssp_pos, 127);
    cfg_write(1'b0, 17'h00000);
    check("R4 presc 0", prescale_eff, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_en = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    meas_start = 1'b0; tx_line = 1'b1; rx_line = 1'b1;
    bit_launch = 1'b0; tx_bit = 1'b0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    repeat (3) step();
    t_cfg();
    t_measure5();
    t_single(1'b1, 1'b0, 1);
    t_single(1'b0, 1'b0, 0);
    t_queue();
    t_disabled();
    t_saturate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule